// File: doc/BRIEF.md
# Interrupt Acknowledge and Completion Controller

This block is the part of one processor's interrupt interface that takes interrupts and retires them. When the processor acknowledges, the block looks at the interrupt that the arbiter reports as most urgent. It grants that interrupt only if its priority value is strictly lower than the priority value now running. On a grant it returns the interrupt number, asks the pending logic to drop the interrupt's pending state, and makes that interrupt the running one. When the processor reports completion, the running interrupt gives way to the one it preempted. The processor may also complete an interrupt that sits lower in the nest. That interrupt is taken out of the nest without disturbing the ones above it.

Nesting is held as one back-link per interrupt number. Each link names the interrupt that was running when that number was granted. Completing the running interrupt costs one cycle. Completing a buried one starts a walk down the links that takes one cycle per step, and `busy` is high for the whole walk. While `busy` is high, acknowledge and completion requests are held off until it falls. A completed level-sensitive source is handed back as pending when it is enabled, still asserted and aimed at this processor. Address decoding and extraction of the interrupt field from a bus word are done outside the block.

Top module: `irq_ack_ctrl`

## Requirements
- R1: After reset, `run_id` is 1023, `run_prio` is 0x100, `busy` is 0, and none of `ack_rsp_valid`, `clr_valid` or `repend_valid` is set.
- R2: An accepted acknowledge returns 1023 and changes neither `run_id` nor `run_prio`, and no clear pulse appears, in any of these cases: `arb_pend_id` is 1023; `arb_pend_id` is not below NUM_IRQ; the priority of `arb_pend_id` is equal to or above `run_prio`.
- R3: An accepted acknowledge whose pending ID is below NUM_IRQ, and whose 8-bit priority (byte `id` of `prio_flat`, bits 8*id+7..8*id) is below `run_prio`, returns that ID in `ack_rsp_id`. In the cycle after the accepting edge, `run_id` becomes that ID and `run_prio` becomes its priority, widened to 9 bits.
- R4: A granted acknowledge pulses `clr_valid` in the same cycle as `ack_rsp_valid`, with `clr_id` set to the granted ID. `clr_all` is that ID's `cfg_one_of_n` bit: 1 clears pending on every processor, 0 clears it only on this one.
- R5: A completion is ignored when `run_id` is 1023 or when `eoi_id` is not below NUM_IRQ. No re-pend pulse appears, `run_id` and `run_prio` do not change, and `busy` stays low.
- R6: A completion that is not ignored pulses `repend_valid` with `repend_id` equal to `eoi_id` when that source has `cfg_edge`=0 (level), `irq_en`=1, `line_level`=1 and `tgt_here`=1.
- R7: Completion of the running ID sets `run_id` to the ID that was running when it was granted. `run_prio` becomes that ID's current priority, or 0x100 when it is 1023. `run_prio` is 0x100 whenever `run_id` is 1023.
- R8: Completion of an ID that is not running raises `busy` for one cycle per back-link examined. If the ID is found in the nest it is removed, so later completions of the interrupts above it skip it. If it is not found the nest is unchanged.
- R9: While `busy` is high no request is accepted. A request held through the busy period is accepted on the first edge with `busy` low.
- R10: When acknowledge and completion are requested in the same cycle, the completion is accepted first and the acknowledge on a later edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ack_req | input | 1 | Acknowledge request, held until accepted |
| eoi_req | input | 1 | Completion request, held until accepted |
| eoi_id | input | 10 | Interrupt ID being completed |
| arb_pend_id | input | 10 | Most urgent pending ID from the arbiter, 1023 for none |
| prio_flat | input | NUM_IRQ*8 | Priority byte of every interrupt, ID n at bits 8n+7..8n |
| cfg_edge | input | NUM_IRQ | 1 = edge-sensitive, 0 = level-sensitive |
| cfg_one_of_n | input | NUM_IRQ | 1 = grant clears pending on all processors |
| irq_en | input | NUM_IRQ | Per-interrupt enable |
| line_level | input | NUM_IRQ | Present level of each interrupt input |
| tgt_here | input | NUM_IRQ | Interrupt is routed to this processor |
| busy | output | 1 | Back-link walk in progress, requests held off |
| ack_rsp_valid | output | 1 | One-cycle pulse per accepted acknowledge |
| ack_rsp_id | output | 10 | ID returned by the acknowledge, 1023 when spurious |
| run_id | output | 10 | Running interrupt, 1023 when none |
| run_prio | output | 9 | Running priority, 0x100 when none |
| clr_valid | output | 1 | Pulse: drop pending state of `clr_id` |
| clr_id | output | 10 | ID whose pending state is dropped |
| clr_all | output | 1 | Drop it for all processors instead of this one |
| repend_valid | output | 1 | Pulse: set pending for `repend_id` on this processor |
| repend_id | output | 10 | Level source to mark pending again |

## Verification
The assertions check several rules on every cycle. A spurious response leaves the running state untouched. A granted ID becomes the running ID. Clear pulses occur only alongside granted responses, and the idle running ID always comes with priority 0x100. A walk starts only from a completion, nothing is accepted during one, and completions while idle have no effect. Only the bench's scenarios can show that the nest unwinds in the right order after a buried interrupt is spliced out. They also show that the walk length tracks the depth of the target, that held requests go through once the walk ends, and that a re-pend is issued only for the exact level, enable, assertion and routing combination.

// File: rtl/irq_ack_pkg.sv
`timescale 1ns/1ps
package irq_ack_pkg;

    localparam int ID_W   = 10;
    localparam int PRIO_W = 8;

    typedef logic [ID_W-1:0]   irq_id_t;
    typedef logic [PRIO_W-1:0] prio_t;
    typedef logic [PRIO_W:0]   run_prio_t;

    localparam irq_id_t   NO_IRQ    = irq_id_t'(1023);
    localparam run_prio_t IDLE_PRIO = run_prio_t'(9'h100);

    typedef enum logic {
        WALK_IDLE,
        WALK_RUN
    } walk_st_e;

    typedef struct packed {
        logic    valid;
        irq_id_t id;
        logic    all;
    } clr_req_t;

    typedef struct packed {
        logic    valid;
        irq_id_t id;
    } repend_req_t;

    function automatic run_prio_t widen_prio(input prio_t p);
        return {1'b0, p};
    endfunction

endpackage

// File: rtl/irq_ack_links.sv
`timescale 1ns/1ps
module irq_ack_links
    import irq_ack_pkg::*;
#(
    parameter int NUM_IRQ = 32,
    parameter int NRD     = 3,
    localparam int IW     = $clog2(NUM_IRQ)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    we,
    input  logic [IW-1:0]           wa,
    input  irq_id_t                 wd,
    input  logic [NRD-1:0][IW-1:0]  ra,
    output irq_id_t [NRD-1:0]       rd
);

    irq_id_t link_q [NUM_IRQ];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NUM_IRQ; i++) begin
                link_q[i] <= NO_IRQ;
            end
        end else if (we) begin
            link_q[wa] <= wd;
        end
    end

    for (genvar g = 0; g < NRD; g++) begin : g_rd
        assign rd[g] = link_q[ra[g]];
    end

endmodule

// File: rtl/irq_ack_prio_sel.sv
`timescale 1ns/1ps
module irq_ack_prio_sel
    import irq_ack_pkg::*;
#(
    parameter int NUM_IRQ = 32,
    parameter int NRD     = 2,
    localparam int IW     = $clog2(NUM_IRQ)
) (
    input  logic [NUM_IRQ*PRIO_W-1:0] prio_flat,
    input  logic [NRD-1:0][IW-1:0]    ra,
    output prio_t [NRD-1:0]           rd
);

    for (genvar g = 0; g < NRD; g++) begin : g_sel
        assign rd[g] = prio_flat[ra[g]*PRIO_W +: PRIO_W];
    end

endmodule

// File: rtl/irq_ack_walker.sv
`timescale 1ns/1ps
module irq_ack_walker
    import irq_ack_pkg::*;
#(
    parameter int NUM_IRQ = 32,
    localparam int IW     = $clog2(NUM_IRQ)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [IW-1:0] start_idx,
    input  logic [IW-1:0] target_idx,
    input  irq_id_t       link_cur,
    output logic          busy,
    output logic [IW-1:0] cur_idx,
    output logic [IW-1:0] tgt_idx,
    output logic          splice_we
);

    walk_st_e      st_q;
    logic [IW-1:0] cur_q;
    logic [IW-1:0] tgt_q;
    logic          hit;
    logic          at_end;

    assign hit       = (st_q == WALK_RUN) && (link_cur == irq_id_t'(tgt_q));
    assign at_end    = (st_q == WALK_RUN) && ((link_cur == NO_IRQ) || hit);
    assign splice_we = hit;
    assign busy      = (st_q == WALK_RUN);
    assign cur_idx   = cur_q;
    assign tgt_idx   = tgt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= WALK_IDLE;
            cur_q <= '0;
            tgt_q <= '0;
        end else if (start) begin
            st_q  <= WALK_RUN;
            cur_q <= start_idx;
            tgt_q <= target_idx;
        end else if (st_q == WALK_RUN) begin
            if (at_end) begin
                st_q <= WALK_IDLE;
            end else begin
                cur_q <= link_cur[IW-1:0];
            end
        end
    end

endmodule

// File: rtl/irq_ack_ctrl.sv
`timescale 1ns/1ps
module irq_ack_ctrl
    import irq_ack_pkg::*;
#(
    parameter int NUM_IRQ = 32,
    localparam int IW     = $clog2(NUM_IRQ)
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      ack_req,
    input  logic                      eoi_req,
    input  logic [ID_W-1:0]           eoi_id,
    input  logic [ID_W-1:0]           arb_pend_id,
    input  logic [NUM_IRQ*PRIO_W-1:0] prio_flat,
    input  logic [NUM_IRQ-1:0]        cfg_edge,
    input  logic [NUM_IRQ-1:0]        cfg_one_of_n,
    input  logic [NUM_IRQ-1:0]        irq_en,
    input  logic [NUM_IRQ-1:0]        line_level,
    input  logic [NUM_IRQ-1:0]        tgt_here,
    output logic                      busy,
    output logic                      ack_rsp_valid,
    output logic [ID_W-1:0]           ack_rsp_id,
    output logic [ID_W-1:0]           run_id,
    output logic [PRIO_W:0]           run_prio,
    output logic                      clr_valid,
    output logic [ID_W-1:0]           clr_id,
    output logic                      clr_all,
    output logic                      repend_valid,
    output logic [ID_W-1:0]           repend_id
);

    localparam irq_id_t ID_LIMIT = irq_id_t'(NUM_IRQ);

    irq_id_t     run_id_q;
    run_prio_t   run_prio_q;
    logic        rsp_valid_q;
    irq_id_t     rsp_id_q;
    clr_req_t    clr_q;
    repend_req_t rep_q;

    logic          walk_busy;
    logic [IW-1:0] walk_cur;
    logic [IW-1:0] walk_tgt;
    logic          splice_we;

    logic [2:0][IW-1:0] link_ra;
    irq_id_t [2:0]      link_rd;
    logic [1:0][IW-1:0] prio_ra;
    prio_t [1:0]        prio_rd;

    logic    accept_eoi, accept_ack;
    logic    running, eoi_in_range, pend_in_range;
    logic    eoi_live, eoi_on_top, eoi_buried;
    logic    ack_grant, level_still_up;
    irq_id_t restore_id;

    logic          lk_we;
    logic [IW-1:0] lk_wa;
    irq_id_t       lk_wd;

    assign running       = (run_id_q != NO_IRQ);
    assign eoi_in_range  = (eoi_id < ID_LIMIT);
    assign pend_in_range = (arb_pend_id < ID_LIMIT);

    // Completion wins over acknowledge; nothing is accepted mid-walk.
    assign accept_eoi = eoi_req && !walk_busy;
    assign accept_ack = ack_req && !walk_busy && !eoi_req;

    assign eoi_live   = accept_eoi && eoi_in_range && running;
    assign eoi_on_top = eoi_live && (eoi_id == run_id_q);
    assign eoi_buried = eoi_live && (eoi_id != run_id_q);

    assign ack_grant = accept_ack && pend_in_range &&
                       (widen_prio(prio_rd[0]) < run_prio_q);

    assign level_still_up = !cfg_edge[eoi_id[IW-1:0]] && irq_en[eoi_id[IW-1:0]] &&
                            line_level[eoi_id[IW-1:0]] && tgt_here[eoi_id[IW-1:0]];

    assign link_ra[0] = run_id_q[IW-1:0];
    assign link_ra[1] = walk_cur;
    assign link_ra[2] = walk_tgt;
    assign restore_id = link_rd[0];

    assign prio_ra[0] = arb_pend_id[IW-1:0];
    assign prio_ra[1] = restore_id[IW-1:0];

    // Grants and splices never share a cycle: grants need the walker idle.
    always_comb begin
        lk_we = 1'b0;
        lk_wa = '0;
        lk_wd = NO_IRQ;
        if (ack_grant) begin
            lk_we = 1'b1;
            lk_wa = arb_pend_id[IW-1:0];
            lk_wd = run_id_q;
        end else if (splice_we) begin
            lk_we = 1'b1;
            lk_wa = walk_cur;
            lk_wd = link_rd[2];
        end
    end

    irq_ack_links #(.NUM_IRQ(NUM_IRQ), .NRD(3)) u_links (
        .clk (clk),
        .rst (rst),
        .we  (lk_we),
        .wa  (lk_wa),
        .wd  (lk_wd),
        .ra  (link_ra),
        .rd  (link_rd)
    );

    irq_ack_prio_sel #(.NUM_IRQ(NUM_IRQ), .NRD(2)) u_prio (
        .prio_flat (prio_flat),
        .ra        (prio_ra),
        .rd        (prio_rd)
    );

    irq_ack_walker #(.NUM_IRQ(NUM_IRQ)) u_walk (
        .clk        (clk),
        .rst        (rst),
        .start      (eoi_buried),
        .start_idx  (run_id_q[IW-1:0]),
        .target_idx (eoi_id[IW-1:0]),
        .link_cur   (link_rd[1]),
        .busy       (walk_busy),
        .cur_idx    (walk_cur),
        .tgt_idx    (walk_tgt),
        .splice_we  (splice_we)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            run_id_q    <= NO_IRQ;
            run_prio_q  <= IDLE_PRIO;
            rsp_valid_q <= 1'b0;
            rsp_id_q    <= NO_IRQ;
            clr_q       <= '{valid: 1'b0, id: NO_IRQ, all: 1'b0};
            rep_q       <= '{valid: 1'b0, id: NO_IRQ};
        end else begin
            rsp_valid_q <= accept_ack;
            clr_q.valid <= ack_grant;
            rep_q.valid <= eoi_live && level_still_up;
            if (accept_ack) begin
                rsp_id_q <= ack_grant ? arb_pend_id : NO_IRQ;
            end
            if (ack_grant) begin
                run_id_q   <= arb_pend_id;
                run_prio_q <= widen_prio(prio_rd[0]);
                clr_q.id   <= arb_pend_id;
                clr_q.all  <= cfg_one_of_n[arb_pend_id[IW-1:0]];
            end
            if (eoi_live) begin
                rep_q.id <= eoi_id;
            end
            if (eoi_on_top) begin
                run_id_q   <= restore_id;
                run_prio_q <= (restore_id == NO_IRQ) ? IDLE_PRIO
                                                     : widen_prio(prio_rd[1]);
            end
        end
    end

    assign busy          = walk_busy;
    assign ack_rsp_valid = rsp_valid_q;
    assign ack_rsp_id    = rsp_id_q;
    assign run_id        = run_id_q;
    assign run_prio      = run_prio_q;
    assign clr_valid     = clr_q.valid;
    assign clr_id        = clr_q.id;
    assign clr_all       = clr_q.all;
    assign repend_valid  = rep_q.valid;
    assign repend_id     = rep_q.id;

endmodule

// File: rtl/irq_ack_ctrl_chk.sv
`timescale 1ns/1ps
module irq_ack_ctrl_chk
    import irq_ack_pkg::*;
(
    input logic            clk,
    input logic            rst,
    input logic            ack_req,
    input logic            eoi_req,
    input logic            busy,
    input logic            ack_rsp_valid,
    input logic [ID_W-1:0] ack_rsp_id,
    input logic [ID_W-1:0] run_id,
    input logic [PRIO_W:0] run_prio,
    input logic            clr_valid,
    input logic [ID_W-1:0] clr_id,
    input logic            repend_valid
);

    // R2
    spurious_keeps_run_chk: assert property (@(posedge clk) disable iff (rst)
        (ack_rsp_valid && ack_rsp_id == NO_IRQ) |-> ($stable(run_id) && $stable(run_prio)));

    // R3
    grant_becomes_running_chk: assert property (@(posedge clk) disable iff (rst)
        (ack_rsp_valid && ack_rsp_id != NO_IRQ) |-> (run_id == ack_rsp_id));

    // R4
    clear_with_grant_chk: assert property (@(posedge clk) disable iff (rst)
        clr_valid |-> (ack_rsp_valid && clr_id == ack_rsp_id));

    // R5
    idle_eoi_noop_chk: assert property (@(posedge clk) disable iff (rst)
        (eoi_req && !busy && run_id == NO_IRQ) |=> (!repend_valid && !busy && run_id == NO_IRQ));

    // R7
    idle_prio_chk: assert property (@(posedge clk) disable iff (rst)
        (run_id == NO_IRQ) |-> (run_prio == IDLE_PRIO));

    // R8
    walk_from_eoi_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(eoi_req));

    // R9
    busy_blocks_chk: assert property (@(posedge clk) disable iff (rst)
        busy |=> (!ack_rsp_valid && !repend_valid));

    // R10
    eoi_first_chk: assert property (@(posedge clk) disable iff (rst)
        (ack_req && eoi_req && !busy) |=> !ack_rsp_valid);

endmodule

bind irq_ack_ctrl irq_ack_ctrl_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .ack_req       (ack_req),
    .eoi_req       (eoi_req),
    .busy          (busy),
    .ack_rsp_valid (ack_rsp_valid),
    .ack_rsp_id    (ack_rsp_id),
    .run_id        (run_id),
    .run_prio      (run_prio),
    .clr_valid     (clr_valid),
    .clr_id        (clr_id),
    .repend_valid  (repend_valid)
);

// File: tb/tb_irq_ack_ctrl.sv
`timescale 1ns/1ps
module tb_irq_ack_ctrl;

    localparam int N = 32;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           ack_req = 1'b0;
    logic           eoi_req = 1'b0;
    logic [9:0]     eoi_id = '0;
    logic [9:0]     arb_pend_id = 10'd1023;
    logic [N*8-1:0] prio_flat;
    logic [N-1:0]   cfg_edge = '1;
    logic [N-1:0]   cfg_one_of_n = '0;
    logic [N-1:0]   irq_en = '0;
    logic [N-1:0]   line_level = '0;
    logic [N-1:0]   tgt_here = '0;
    logic           busy, ack_rsp_valid, clr_valid, clr_all, repend_valid;
    logic [9:0]     ack_rsp_id, run_id, clr_id, repend_id;
    logic [8:0]     run_prio;

    irq_ack_ctrl #(.NUM_IRQ(N)) dut (
        .clk(clk), .rst(rst), .ack_req(ack_req), .eoi_req(eoi_req), .eoi_id(eoi_id),
        .arb_pend_id(arb_pend_id), .prio_flat(prio_flat), .cfg_edge(cfg_edge),
        .cfg_one_of_n(cfg_one_of_n), .irq_en(irq_en), .line_level(line_level),
        .tgt_here(tgt_here), .busy(busy), .ack_rsp_valid(ack_rsp_valid),
        .ack_rsp_id(ack_rsp_id), .run_id(run_id), .run_prio(run_prio),
        .clr_valid(clr_valid), .clr_id(clr_id), .clr_all(clr_all),
        .repend_valid(repend_valid), .repend_id(repend_id)
    );

    always #10 clk = ~clk;

    int    n_cmp = 0;
    int    n_bad = 0;
    string tag = "R1";

    // Reference model: the nest is a queue, most recent grant at the back.
    int q[$];
    int m_prio = 256;
    int m_walk = 0;
    bit m_found = 0;
    int m_del = 0;
    bit m_rsp_v = 0, m_clr_v = 0, m_clr_all = 0, m_rep_v = 0;
    int m_rsp_id = 1023, m_clr_id = 0, m_rep_id = 0;
    bit acc_ack = 0, acc_eoi = 0;

    function automatic int pr(input int i);
        return int'(prio_flat[i*8 +: 8]);
    endfunction

    function automatic int m_run();
        return (q.size() == 0) ? 1023 : q[q.size()-1];
    endfunction

    always @(posedge clk) begin
        m_rsp_v = 0; m_clr_v = 0; m_rep_v = 0; acc_ack = 0; acc_eoi = 0;
        if (rst) begin
            q.delete(); m_prio = 256; m_walk = 0; m_found = 0;
        end else if (m_walk != 0) begin
            m_walk--;
            if (m_walk == 0 && m_found) q.delete(m_del);
        end else if (eoi_req) begin
            int id;
            id = int'(eoi_id);
            acc_eoi = 1;
            if (q.size() > 0 && id < N) begin
                if (!cfg_edge[id] && irq_en[id] && line_level[id] && tgt_here[id]) begin
                    m_rep_v = 1; m_rep_id = id;
                end
                if (id == m_run()) begin
                    void'(q.pop_back());
                    m_prio = (q.size() == 0) ? 256 : pr(m_run());
                end else begin
                    m_found = 0;
                    m_walk = q.size();
                    for (int k = q.size() - 2; k >= 0; k--) begin
                        if (!m_found && q[k] == id) begin
                            m_found = 1; m_del = k; m_walk = q.size() - 1 - k;
                        end
                    end
                end
            end
        end else if (ack_req) begin
            int pid;
            pid = int'(arb_pend_id);
            acc_ack = 1;
            m_rsp_v = 1;
            if (pid < N && pr(pid) < m_prio) begin
                q.push_back(pid);
                m_prio = pr(pid);
                m_rsp_id = pid;
                m_clr_v = 1; m_clr_id = pid; m_clr_all = cfg_one_of_n[pid];
            end else begin
                m_rsp_id = 1023;
            end
        end
    end

    task automatic cmp(input string what, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (!rst) begin
            cmp("busy", int'(busy), (m_walk != 0) ? 1 : 0);
            cmp("run_id", int'(run_id), m_run());
            cmp("run_prio", int'(run_prio), m_prio);
            cmp("ack_rsp_valid", int'(ack_rsp_valid), int'(m_rsp_v));
            if (m_rsp_v) cmp("ack_rsp_id", int'(ack_rsp_id), m_rsp_id);
            cmp("clr_valid", int'(clr_valid), int'(m_clr_v));
            if (m_clr_v) begin
                cmp("clr_id", int'(clr_id), m_clr_id);
                cmp("clr_all", int'(clr_all), int'(m_clr_all));
            end
            cmp("repend_valid", int'(repend_valid), int'(m_rep_v));
            if (m_rep_v) cmp("repend_id", int'(repend_id), m_rep_id);
        end
    end

    task automatic do_ack(input int pid);
        arb_pend_id = 10'(pid);
        ack_req = 1'b1;
        do @(negedge clk); while (!acc_ack);
        ack_req = 1'b0;
    endtask

    task automatic do_eoi(input int id);
        eoi_id = 10'(id);
        eoi_req = 1'b1;
        do @(negedge clk); while (!acc_eoi);
        eoi_req = 1'b0;
    endtask

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        for (int i = 0; i < N; i++) prio_flat[i*8 +: 8] = 8'(240 - 6 * i);
        cfg_one_of_n[5] = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset state seen right after release
        tag = "R1";
        cmp("reset run_id", int'(run_id), 1023);
        cmp("reset run_prio", int'(run_prio), 256);
        cmp("reset busy", int'(busy), 0);
        cmp("reset pulses", int'({ack_rsp_valid, clr_valid, repend_valid}), 0);
        settle(2);

        tag = "R2";
        do_ack(1023);
        do_ack(40);
        settle(1);

        tag = "R3";
        do_ack(5);
        tag = "R4";
        do_ack(10);
        settle(1);

        tag = "R2";
        do_ack(3);
        do_ack(10);
        settle(1);

        tag = "R6";
        cfg_edge[10] = 1'b0; irq_en[10] = 1'b1; line_level[10] = 1'b1; tgt_here[10] = 1'b1;
        do_eoi(10);
        settle(1);
        tag = "R7";
        do_eoi(5);
        settle(1);

        tag = "R5";
        do_eoi(10);
        settle(1);
        do_ack(2);
        do_eoi(50);
        do_eoi(1023);
        settle(1);

        tag = "R6";
        cfg_edge[6] = 1'b0; irq_en[6] = 1'b1; line_level[6] = 1'b1; tgt_here[6] = 1'b0;
        do_ack(6);
        do_ack(12);
        do_ack(20);

        tag = "R8";
        do_eoi(9);
        settle(5);
        do_eoi(6);
        tag = "R9";
        do_ack(25);
        settle(1);

        tag = "R7";
        do_eoi(25);
        do_eoi(20);
        do_eoi(12);
        settle(1);
        do_eoi(2);
        settle(1);

        tag = "R10";
        do_ack(4);
        eoi_id = 10'd4; eoi_req = 1'b1;
        arb_pend_id = 10'd7; ack_req = 1'b1;
        @(negedge clk);
        eoi_req = 1'b0;
        do @(negedge clk); while (!acc_ack);
        ack_req = 1'b0;
        do_eoi(7);
        settle(3);

        finish_run();
    end

endmodule